// File: doc/BRIEF.md
# Multichannel Zero-Detect Mute Controller

This block sits in front of a six-channel converter bank. It takes six parallel audio sample streams that share one valid strobe. It registers them and passes them on. Any channel pair whose hard-mute bit is set is forced to zero on the way. It also drives an active-low mute pin for the analog stage. The pin is held low while a software override bit is set. It is also held low while auto-mute is enabled and all six channels have been zero together for a long run of accepted samples.

Software controls the block through one control byte, written and read over a small register port. The byte resets with the override set, so the pin leaves reset asserted. Software normally clears the override once the converters are ready. After that, auto-mute looks after silence: a single non-zero sample on any channel releases the pin on the same clock edge that accepts that sample.

Top module: `zmute_ctrl`

## Requirements
- R1: While rst_n is low and right after reset, cfg_rd_data reads 0x80, mute_n_o is 0, smp_valid_o is 0 and smp_data_o is all zero.
- R2: Control bit 7 (override) set to 1 holds mute_n_o at 0. The pin is registered, so a change of bit 7 reaches the pin one clock after the write edge.
- R3: With bit 6 (auto-mute enable) at 1 and bit 7 at 0, mute_n_o falls on the edge that accepts the 512th consecutive valid sample in which all six channels are zero. After 511 such samples it is still 1.
- R4: A valid sample with any channel non-zero drives mute_n_o to 1 on the edge that accepts it (with bit 7 at 0). The zero run then starts again from 0.
- R5: Only cycles with smp_valid_i high count toward the run, and cycles without it do not break the run. The run saturates, so the pin stays low for any number of zero samples beyond 512.
- R6: While bit 6 is 0 the run is cleared and auto-mute cannot assert the pin. After re-enabling, a full 512 new zero samples are needed.
- R7: Channel k occupies smp_data_i/smp_data_o bits [24k+23:24k]. Bit 2 hard-mutes channels 0 and 1, bit 3 channels 2 and 3, bit 4 channels 4 and 5. A valid sample is output one clock later, with the channels of every hard-muted pair replaced by zero and the other channels unchanged.
- R8: smp_valid_o is smp_valid_i delayed by one clock. smp_data_o holds its value in cycles without a valid input.
- R9: A write stores bits 7, 6 and 4..2. Reserved bits 5, 1 and 0 ignore writes and read as 0, so writing 0xFF reads back 0xDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Control byte write strobe |
| cfg_wr_data | input | 8 | Control byte write value |
| cfg_rd_data | output | 8 | Control byte read value |
| smp_valid_i | input | 1 | Input sample strobe shared by all channels |
| smp_data_i | input | 144 | Six packed 24-bit input samples |
| smp_valid_o | output | 1 | Output sample strobe |
| smp_data_o | output | 144 | Six packed 24-bit output samples after hard mute |
| mute_n_o | output | 1 | Active-low mute pin |

## Verification
The assertions assume that the inputs are driven to known values whenever rst_n is high. They also assume that cfg_rd_data mirrors the control state that the pin and the gate use in the same cycle. The bench drives every input from its tasks away from the active edge, and it never leaves the strobe or the data undriven. Random samples are zero most of the time, with rare non-zero channels, so 512-sample zero runs occur naturally. Random control writes mostly keep the override clear and auto-mute enabled, so the run counter is exercised rather than masked.

// File: rtl/zmute_pkg.sv
// Package: shared constants and the control byte type of the mute controller.
// Assumes: exactly three channel pairs, one hard-mute bit for each.
package zmute_pkg;

    localparam int NUM_PAIRS = 3;
    localparam int CH_NUM    = 2 * NUM_PAIRS;

    // Bit positions inside the control byte (software-visible layout)
    localparam int OVR_BIT   = 7;
    localparam int AUTO_BIT  = 6;
    localparam int HM_LO_BIT = 2;

    localparam logic [7:0] CFG_RESET = 8'h80;

    typedef struct packed {
        logic                 ovr;
        logic                 auto_en;
        logic [NUM_PAIRS-1:0] hard_mute;
    } zmute_cfg_t;

endpackage

// File: rtl/zmute_cfg_reg.sv
// Module: holds the control byte.
// Stores the override, auto-mute enable and hard-mute fields.
// Reserved positions are never stored and read back as zero.
// Assumes: a single write port; writes take effect on the clock edge.
module zmute_cfg_reg
    import zmute_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output zmute_cfg_t cfg_o,
    output logic [7:0] rd_data_o
);

    zmute_cfg_t cfg_q;

    // Update the stored fields on a write; the reset value sets only the override
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.ovr       <= CFG_RESET[OVR_BIT];
            cfg_q.auto_en   <= CFG_RESET[AUTO_BIT];
            cfg_q.hard_mute <= CFG_RESET[HM_LO_BIT +: NUM_PAIRS];
        end else if (wr_en) begin
            cfg_q.ovr       <= wr_data[OVR_BIT];
            cfg_q.auto_en   <= wr_data[AUTO_BIT];
            cfg_q.hard_mute <= wr_data[HM_LO_BIT +: NUM_PAIRS];
        end
    end

    // Assemble the read value with reserved bits at zero
    always_comb begin
        rd_data_o                         = 8'h00;
        rd_data_o[OVR_BIT]                = cfg_q.ovr;
        rd_data_o[AUTO_BIT]               = cfg_q.auto_en;
        rd_data_o[HM_LO_BIT +: NUM_PAIRS] = cfg_q.hard_mute;
    end

    assign cfg_o = cfg_q;

    // Reserved write bits are intentionally dropped
    logic unused_wr;
    assign unused_wr = ^{wr_data[5], wr_data[1:0]};

endmodule

// File: rtl/zmute_zero_run.sv
// Module: counts consecutive accepted samples in which every channel is zero.
// The count saturates at RUN_LEN. It clears on a non-zero sample and while
// auto-mute is disabled. hit_next_o is the auto-mute condition as it will be
// after this edge, so the pin register follows the run without extra delay.
// Assumes: all channels share one valid strobe.
module zmute_zero_run #(
    parameter int CH_NUM  = 6,
    parameter int SMP_W   = 24,
    parameter int RUN_LEN = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    auto_en,
    input  logic                    smp_valid,
    input  logic [CH_NUM*SMP_W-1:0] smp_data,
    output logic                    hit_next_o
);

    localparam int              CNT_W   = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    logic [CH_NUM-1:0] ch_zero;
    logic              all_zero;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;

    // One zero detector for each channel
    for (genvar k = 0; k < CH_NUM; k++) begin : g_ch_zero
        assign ch_zero[k] = ~|smp_data[k*SMP_W +: SMP_W];
    end

    assign all_zero = &ch_zero;

    // Next run length: clear when disabled or on a non-zero sample, saturate at the limit
    always_comb begin
        cnt_d = cnt_q;
        if (!auto_en) begin
            cnt_d = '0;
        end else if (smp_valid) begin
            if (!all_zero) begin
                cnt_d = '0;
            end else if (cnt_q != CNT_MAX) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // Hold the run length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit_next_o = (cnt_d == CNT_MAX);

endmodule

// File: rtl/zmute_pair_gate.sv
// Module: registers the sample bus and forces hard-muted pairs to zero.
// Data is held when no sample is accepted.
// Assumes: the hard-mute bits are stable registers from the control byte.
module zmute_pair_gate #(
    parameter int NUM_PAIRS = 3,
    parameter int SMP_W     = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         valid_i,
    input  logic [2*NUM_PAIRS*SMP_W-1:0] data_i,
    input  logic [NUM_PAIRS-1:0]         hard_mute,
    output logic                         valid_o,
    output logic [2*NUM_PAIRS*SMP_W-1:0] data_o
);

    localparam int PAIR_W = 2 * SMP_W;

    // Delay the strobe by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= valid_i;
        end
    end

    // One output register for each pair, zeroed under hard mute
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_o[p*PAIR_W +: PAIR_W] <= '0;
            end else if (valid_i) begin
                data_o[p*PAIR_W +: PAIR_W] <= hard_mute[p] ? '0
                                                           : data_i[p*PAIR_W +: PAIR_W];
            end
        end
    end

endmodule

// File: rtl/zmute_pin_drv.sv
// Module: drives the registered, glitch-free, active-low mute pin.
// Assumes: auto_hit is the auto-mute condition of the coming cycle.
module zmute_pin_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr,
    input  logic auto_hit,
    output logic mute_n_o
);

    // Pin is low in reset and whenever either mute source is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_n_o <= 1'b0;
        end else begin
            mute_n_o <= ~(ovr | auto_hit);
        end
    end

endmodule

// File: rtl/zmute_ctrl.sv
// Module: top of the multichannel zero-detect mute controller.
// Connects the control byte, the zero-run counter, the pair gate and the pin driver.
// Assumes: six channels of SMP_W bits packed with channel 0 in the low bits.
module zmute_ctrl #(
    parameter int SMP_W   = 24,
    parameter int RUN_LEN = 512
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cfg_wr_en,
    input  logic [7:0]                            cfg_wr_data,
    output logic [7:0]                            cfg_rd_data,
    input  logic                                  smp_valid_i,
    input  logic [zmute_pkg::CH_NUM*SMP_W-1:0]    smp_data_i,
    output logic                                  smp_valid_o,
    output logic [zmute_pkg::CH_NUM*SMP_W-1:0]    smp_data_o,
    output logic                                  mute_n_o
);
    import zmute_pkg::*;

    zmute_cfg_t cfg;
    logic       auto_hit;

    zmute_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_data   (cfg_wr_data),
        .cfg_o     (cfg),
        .rd_data_o (cfg_rd_data)
    );

    zmute_zero_run #(
        .CH_NUM  (CH_NUM),
        .SMP_W   (SMP_W),
        .RUN_LEN (RUN_LEN)
    ) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (cfg.auto_en),
        .smp_valid  (smp_valid_i),
        .smp_data   (smp_data_i),
        .hit_next_o (auto_hit)
    );

    zmute_pair_gate #(
        .NUM_PAIRS (NUM_PAIRS),
        .SMP_W     (SMP_W)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (smp_valid_i),
        .data_i    (smp_data_i),
        .hard_mute (cfg.hard_mute),
        .valid_o   (smp_valid_o),
        .data_o    (smp_data_o)
    );

    zmute_pin_drv u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr      (cfg.ovr),
        .auto_hit (auto_hit),
        .mute_n_o (mute_n_o)
    );

endmodule

// File: rtl/zmute_ctrl_chk.sv
// Module: property checker for zmute_ctrl, attached by bind.
// Assumes: inputs are driven to known values while rst_n is high.
module zmute_ctrl_chk #(
    parameter int SMP_W = 24
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [7:0]           cfg_rd_data,
    input logic                 smp_valid_i,
    input logic [6*SMP_W-1:0]   smp_data_i,
    input logic                 smp_valid_o,
    input logic [6*SMP_W-1:0]   smp_data_o,
    input logic                 mute_n_o
);

    // R2
    ovr_forces_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[7] |=> !mute_n_o);

    // R4
    nonzero_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && (|smp_data_i) && !cfg_rd_data[7]) |=> mute_n_o);

    // R6
    auto_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rd_data[6] && !cfg_rd_data[7]) |=> mute_n_o);

    // R7
    pair0_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && cfg_rd_data[2]) |=> (smp_data_o[2*SMP_W-1:0] == '0));

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_i |=> smp_valid_o);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> (!smp_valid_o && $stable(smp_data_o)));

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_data & 8'h23) == 8'h00);

endmodule

bind zmute_ctrl zmute_ctrl_chk #(.SMP_W(SMP_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rd_data (cfg_rd_data),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .smp_valid_o (smp_valid_o),
    .smp_data_o  (smp_data_o),
    .mute_n_o    (mute_n_o)
);

// File: tb/zmute_ctrl_bench.sv
// Bench: directed corner cases plus seeded random samples and control writes.
// Expected values come from bench functions written from the requirements.
module zmute_ctrl_bench;

    localparam int SW  = 24;
    localparam int RUN = 512;
    localparam int DW  = 6 * SW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_wr_en;
    logic [7:0]    cfg_wr_data;
    logic [7:0]    cfg_rd_data;
    logic          smp_valid_i;
    logic [DW-1:0] smp_data_i;
    logic          smp_valid_o;
    logic [DW-1:0] smp_data_o;
    logic          mute_n_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Model state
    logic          m_ovr, m_en;
    logic [2:0]    m_hm;
    int            m_run;
    logic          e_pin, e_vo;
    logic [DW-1:0] e_do;

    always #2 clk = ~clk;

    zmute_ctrl #(.SMP_W(SW), .RUN_LEN(RUN)) u_zmute_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .smp_valid_i (smp_valid_i),
        .smp_data_i  (smp_data_i),
        .smp_valid_o (smp_valid_o),
        .smp_data_o  (smp_data_o),
        .mute_n_o    (mute_n_o)
    );

    // Expected output sample under hard mute (R7)
    function automatic logic [DW-1:0] gate(input logic [DW-1:0] d, input logic [2:0] hm);
        logic [DW-1:0] r = d;
        for (int p = 0; p < 3; p++)
            if (hm[p]) r[p*2*SW +: 2*SW] = '0;
        return r;
    endfunction

    // Expected run length after one edge (R3..R6)
    function automatic int run_next(input int run, input logic en, input logic v,
                                    input logic [DW-1:0] d);
        if (!en) return 0;
        if (!v) return run;
        if (d != '0) return 0;
        return (run >= RUN) ? RUN : run + 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, compare
    task automatic cyc(input logic wr, input logic [7:0] wd, input logic v,
                       input logic [DW-1:0] d);
        @(negedge clk);
        cfg_wr_en   = wr;
        cfg_wr_data = wd;
        smp_valid_i = v;
        smp_data_i  = d;
        @(posedge clk);
        #1;
        e_vo = v;
        if (v) e_do = gate(d, m_hm);
        m_run = run_next(m_run, m_en, v, d);
        e_pin = !(m_ovr || (m_run == RUN));
        if (wr) begin
            m_ovr = wd[7];
            m_en  = wd[6];
            m_hm  = wd[4:2];
        end
        chk(mute_n_o == e_pin, "R3 pin", $sformatf("%b", mute_n_o), $sformatf("%b", e_pin));
        chk(smp_valid_o == e_vo, "R8 valid", $sformatf("%b", smp_valid_o), $sformatf("%b", e_vo));
        chk(smp_data_o == e_do, "R7 data", $sformatf("%h", smp_data_o), $sformatf("%h", e_do));
        chk(cfg_rd_data == {m_ovr, m_en, 1'b0, m_hm, 2'b00}, "R9 readback",
            $sformatf("%h", cfg_rd_data), $sformatf("%h", {m_ovr, m_en, 1'b0, m_hm, 2'b00}));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, '0);
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b1, '0);
    endtask

    task automatic wr(input logic [7:0] b);
        cyc(1'b1, b, 1'b0, '0);
    endtask

    function automatic logic [DW-1:0] rnd_data(input int nz_per);
        logic [DW-1:0] r = '0;
        for (int k = 0; k < 6; k++)
            if (($urandom % nz_per) == 0) r[k*SW +: SW] = SW'($urandom);
        return r;
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 4);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = 8'h00;
        smp_valid_i = 1'b0; smp_data_i = '0;
        m_ovr = 1'b1; m_en = 1'b0; m_hm = 3'b000; m_run = 0;
        e_pin = 1'b0; e_vo = 1'b0; e_do = '0;

        // R1: reset state, also while a write and sample are presented
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = 8'h5C;
        smp_valid_i = 1'b1; smp_data_i = {DW{1'b1}};
        repeat (3) @(posedge clk);
        #1;
        chk(cfg_rd_data == 8'h80, "R1 reset readback", $sformatf("%h", cfg_rd_data), "80");
        chk(mute_n_o == 1'b0, "R1 reset pin", $sformatf("%b", mute_n_o), "0");
        chk(smp_valid_o == 1'b0 && smp_data_o == '0, "R1 reset outputs",
            $sformatf("%b/%h", smp_valid_o, smp_data_o), "0/0");
        @(negedge clk); rst_n = 1'b1; cfg_wr_en = 1'b0; smp_valid_i = 1'b0; smp_data_i = '0;
        idle(2);
        chk(mute_n_o == 1'b0, "R1 pin after reset", $sformatf("%b", mute_n_o), "0");

        // R2: override cleared releases the pin one clock after the write
        wr(8'h00);
        chk(mute_n_o == 1'b0, "R2 pin at write edge", $sformatf("%b", mute_n_o), "0");
        idle(1);
        chk(mute_n_o == 1'b1, "R2 pin released", $sformatf("%b", mute_n_o), "1");
        wr(8'h80); idle(1);
        chk(mute_n_o == 1'b0, "R2 override set", $sformatf("%b", mute_n_o), "0");
        wr(8'h00); idle(1);

        // R3: 511 zero samples keep the pin high, the 512th drops it
        wr(8'h40);
        zeros(RUN - 1);
        chk(mute_n_o == 1'b1, "R3 after 511 zeros", $sformatf("%b", mute_n_o), "1");
        zeros(1);
        chk(mute_n_o == 1'b0, "R3 after 512 zeros", $sformatf("%b", mute_n_o), "0");

        // R5: gaps and a long run keep the saturated mute
        idle(5); zeros(700);
        chk(mute_n_o == 1'b0, "R5 saturated", $sformatf("%b", mute_n_o), "0");

        // R4: one non-zero sample on channel 5 releases on the accepting edge
        d = '0; d[5*SW] = 1'b1;
        cyc(1'b0, 8'h00, 1'b1, d);
        chk(mute_n_o == 1'b1, "R4 release", $sformatf("%b", mute_n_o), "1");

        // R5: invalid cycles between zero samples do not break the run
        for (int i = 0; i < RUN - 1; i++) begin
            zeros(1);
            if (i % 3 == 0) idle(1);
        end
        chk(mute_n_o == 1'b1, "R5 511 with gaps", $sformatf("%b", mute_n_o), "1");
        zeros(1);
        chk(mute_n_o == 1'b0, "R5 512 with gaps", $sformatf("%b", mute_n_o), "0");

        // R6: disabling releases and clears; re-enable needs a fresh run
        wr(8'h00); idle(1);
        chk(mute_n_o == 1'b1, "R6 disabled", $sformatf("%b", mute_n_o), "1");
        wr(8'h40); zeros(RUN - 1);
        chk(mute_n_o == 1'b1, "R6 fresh run 511", $sformatf("%b", mute_n_o), "1");
        zeros(1);
        chk(mute_n_o == 1'b0, "R6 fresh run 512", $sformatf("%b", mute_n_o), "0");

        // R7: each pair alone, then all pairs
        for (int p = 0; p < 4; p++) begin
            logic [7:0] b = (p == 3) ? 8'h1C : 8'(1 << (p + 2));
            wr(b);
            d = {DW{1'b1}};
            cyc(1'b0, 8'h00, 1'b1, d);
            chk(smp_data_o == gate(d, b[4:2]), "R7 pair select",
                $sformatf("%h", smp_data_o), $sformatf("%h", gate(d, b[4:2])));
        end

        // R9: reserved bits dropped
        wr(8'hFF);
        chk(cfg_rd_data == 8'hDC, "R9 reserved", $sformatf("%h", cfg_rd_data), "dc");
        wr(8'h00); idle(1);

        // Random traffic with occasional writes
        for (int i = 0; i < 12000; i++) begin
            logic w = (($urandom % 400) == 0);
            logic [7:0] b = 8'($urandom);
            b[7] = (($urandom % 8) == 0);
            b[6] = (($urandom % 6) != 0);
            cyc(w, b, (($urandom % 4) != 0), rnd_data(900));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule